// File: doc/BRIEF.md
# DMA Channel Address, Count and End-of-Transfer Unit

This block keeps the address and transfer-count state of a four-channel programmable DMA controller and decides what each channel does when its transfer ends. Software loads each channel's starting address and count as two byte writes. The same write lands in a base copy and in a working copy. A sequencer outside this block issues one step pulse per transfer. Each step moves the working address by one, up or down, and lowers the working count by one.

A channel finishes in one of two ways: its count runs past zero, or an end-of-process input arrives. If the channel is set to reinitialize itself, the working registers are restored from the base copy. If it is not, the channel's mask bit is set so that further requests are blocked. When memory-to-memory mode is on, the external end-of-process input ends channels 0 and 1 together. Channel 0, the source side, is never restored by that input. Channel 1 is.

Top module: `dma_cnt_unit`

## Requirements
- R1: After reset, all mask bits are 1, every working and base address and count is 0, the terminal-count flags are 0, the byte pointer selects the low byte, and no channel has self-reinitialize or down-counting set.
- R2: A register write with `wr_sel`=0 (address) or `wr_sel`=1 (count) stores `wr_data` in the low byte when the shared byte pointer is low and in the high byte when it is high. The pointer flips on every write. Each write updates the base copy and the working copy of the same register.
- R3: A pulse on `clr_ptr` returns the byte pointer to the low byte, whatever is on `wr_data`.
- R4: A step on a channel lowers its working count by 1. It raises the working address by 1 when that channel's down bit is 0 and lowers it by 1 when the bit is 1, wrapping modulo 2^16.
- R5: A channel loaded with count N reaches terminal count on its (N+1)th step, the step taken while the count reads 0. The matching bit of `tc_o` is 1 for exactly the one cycle that follows that step.
- R6: At terminal count with self-reinitialize set, the working address and count are restored from the base copy and the mask bit keeps its value.
- R7: At terminal count without self-reinitialize, the mask bit is set, the count reads 0xFFFF and the address holds its stepped value.
- R8: With memory-to-memory mode off, `ext_eop` high during a step ends the stepped channel only. That channel's step is still applied, and it is then restored (R6) or masked (R7) by its mode, with `tc_o` staying 0.
- R9: With memory-to-memory mode on, `ext_eop` ends channels 0 and 1 with or without a step. Channel 1 is restored if it has self-reinitialize set. Channel 0 keeps its working values and has its mask set even when self-reinitialize is on.
- R10: A mask write sets one channel's mask bit to `mask_val`. When an end of process sets the mask in the same cycle, the set wins.
- R11: In a cycle with no register write, no step and no `ext_eop`, no address or count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_sel | input | 1 | 0 = address register, 1 = count register |
| wr_ch | input | 2 | Channel of the write |
| wr_data | input | 8 | Byte written |
| clr_ptr | input | 1 | Byte pointer clear command |
| mode_wr | input | 1 | Mode setting strobe |
| mode_ch | input | 2 | Channel of the mode setting |
| mode_auto | input | 1 | Self-reinitialize enable |
| mode_dec | input | 1 | Address counts down when 1 |
| mask_wr | input | 1 | Single mask bit write strobe |
| mask_ch | input | 2 | Channel of the mask write |
| mask_val | input | 1 | Mask bit value |
| step | input | 1 | One transfer completed |
| step_ch | input | 2 | Channel of the step |
| ext_eop | input | 1 | External end-of-process |
| m2m | input | 1 | Memory-to-memory mode |
| addr_o | output | 64 | Working addresses, channel c at bits 16c+15:16c |
| cnt_o | output | 64 | Working counts, channel c at bits 16c+15:16c |
| tc_o | output | 4 | Terminal-count pulse per channel |
| mask_o | output | 4 | Mask bit per channel |

## Verification
Each channel's working address and count appear at the ports after every cycle. A wrong step direction, a missed decrement or a corrupted byte therefore shows on the very next cycle. A fault in the end-of-process choice, whether a wrong restore, a missing mask or channel 0 being restored, shows up in the cycle that follows the final step or the external end pulse: the registers go back to their base values, or the mask comes up, or neither happens. A byte-pointer fault shows only once a 16-bit value has been loaded, as swapped or misplaced bytes.

// File: rtl/dmacu_pkg.sv
package dmacu_pkg;
   localparam int BYTE_W = 8;
   typedef enum logic {SEL_ADDR = 1'b0, SEL_CNT = 1'b1} dmacu_sel_e;
endpackage

// File: rtl/dmacu_byteptr.sv
module dmacu_byteptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flip,
   output logic hi_o
);
   logic ptr_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr_q <= 1'b0;
      else if (clr)  ptr_q <= 1'b0;
      else if (flip) ptr_q <= ~ptr_q;
   end
   assign hi_o = ptr_q;
endmodule

// File: rtl/dmacu_chan.sv
module dmacu_chan #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_a_lo,
   input  logic          wr_a_hi,
   input  logic          wr_c_lo,
   input  logic          wr_c_hi,
   input  logic [7:0]    wr_byte,
   input  logic          mode_wr,
   input  logic          mode_auto,
   input  logic          mode_dec,
   input  logic          mask_wr,
   input  logic          mask_val,
   input  logic          step,
   input  logic          ext_end,
   input  logic          block_reload,
   output logic [AW-1:0] addr_o,
   output logic [CW-1:0] cnt_o,
   output logic          tc_o,
   output logic          mask_o
);
   import dmacu_pkg::*;
   localparam int AHI = AW - BYTE_W;
   localparam int CHI = CW - BYTE_W;

   logic [AW-1:0] base_a, cur_a, a_next;
   logic [CW-1:0] base_c, cur_c;
   logic          auto_q, dec_q, tc_q, mask_q;
   logic          step_tc, finish, reload;

   always_comb begin
      step_tc = step && (cur_c == '0);
      finish  = step_tc || ext_end;
      reload  = auto_q && (step_tc || (ext_end && !block_reload));
      a_next  = dec_q ? cur_a - AW'(1) : cur_a + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_a <= '0;
         cur_a  <= '0;
         base_c <= '0;
         cur_c  <= '0;
         auto_q <= 1'b0;
         dec_q  <= 1'b0;
         tc_q   <= 1'b0;
         mask_q <= 1'b1;
      end else begin
         if (mode_wr) begin
            auto_q <= mode_auto;
            dec_q  <= mode_dec;
         end
         if (wr_a_lo) begin
            base_a[BYTE_W-1:0] <= wr_byte;
            cur_a[BYTE_W-1:0]  <= wr_byte;
         end else if (wr_a_hi) begin
            base_a[AW-1:BYTE_W] <= wr_byte[AHI-1:0];
            cur_a[AW-1:BYTE_W]  <= wr_byte[AHI-1:0];
         end else if (reload) begin
            cur_a <= base_a;
         end else if (step) begin
            cur_a <= a_next;
         end
         if (wr_c_lo) begin
            base_c[BYTE_W-1:0] <= wr_byte;
            cur_c[BYTE_W-1:0]  <= wr_byte;
         end else if (wr_c_hi) begin
            base_c[CW-1:BYTE_W] <= wr_byte[CHI-1:0];
            cur_c[CW-1:BYTE_W]  <= wr_byte[CHI-1:0];
         end else if (reload) begin
            cur_c <= base_c;
         end else if (step) begin
            cur_c <= cur_c - CW'(1);
         end
         tc_q <= step_tc;
         if (finish && !reload) mask_q <= 1'b1;
         else if (mask_wr)      mask_q <= mask_val;
      end
   end

   assign addr_o = cur_a;
   assign cnt_o  = cur_c;
   assign tc_o   = tc_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
   parameter int NUM_CH = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [CHW-1:0]       wr_ch,
   input  logic [7:0]           wr_data,
   input  logic                 clr_ptr,
   input  logic                 mode_wr,
   input  logic [CHW-1:0]       mode_ch,
   input  logic                 mode_auto,
   input  logic                 mode_dec,
   input  logic                 mask_wr,
   input  logic [CHW-1:0]       mask_ch,
   input  logic                 mask_val,
   input  logic                 step,
   input  logic [CHW-1:0]       step_ch,
   input  logic                 ext_eop,
   input  logic                 m2m,
   output logic [NUM_CH*AW-1:0] addr_o,
   output logic [NUM_CH*CW-1:0] cnt_o,
   output logic [NUM_CH-1:0]    tc_o,
   output logic [NUM_CH-1:0]    mask_o
);
   import dmacu_pkg::*;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("dma_cnt_unit: NUM_CH must be at least 2 for memory-to-memory pairing");
   end
   if (AW <= BYTE_W || AW > 2*BYTE_W) begin : g_bad_aw
      $error("dma_cnt_unit: AW must lie in 9..16 for two byte writes");
   end
   if (CW <= BYTE_W || CW > 2*BYTE_W) begin : g_bad_cw
      $error("dma_cnt_unit: CW must lie in 9..16 for two byte writes");
   end

   logic ptr_hi;

   dmacu_byteptr u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_ptr),
      .flip (wr_en),
      .hi_o (ptr_hi)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_w, a_lo, a_hi, c_lo, c_hi, ext_c, blk_c, step_c;
      assign sel_w  = wr_en && (wr_ch == CHW'(c));
      assign a_lo   = sel_w && (wr_sel == SEL_ADDR) && !ptr_hi;
      assign a_hi   = sel_w && (wr_sel == SEL_ADDR) &&  ptr_hi;
      assign c_lo   = sel_w && (wr_sel == SEL_CNT)  && !ptr_hi;
      assign c_hi   = sel_w && (wr_sel == SEL_CNT)  &&  ptr_hi;
      assign step_c = step && (step_ch == CHW'(c));
      if (c < 2) begin : g_pair
         assign ext_c = m2m ? ext_eop : (ext_eop && step_c);
      end else begin : g_solo
         assign ext_c = !m2m && ext_eop && step_c;
      end
      if (c == 0) begin : g_src
         assign blk_c = m2m;
      end else begin : g_oth
         assign blk_c = 1'b0;
      end

      dmacu_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_a_lo     (a_lo),
         .wr_a_hi     (a_hi),
         .wr_c_lo     (c_lo),
         .wr_c_hi     (c_hi),
         .wr_byte     (wr_data),
         .mode_wr     (mode_wr && (mode_ch == CHW'(c))),
         .mode_auto   (mode_auto),
         .mode_dec    (mode_dec),
         .mask_wr     (mask_wr && (mask_ch == CHW'(c))),
         .mask_val    (mask_val),
         .step        (step_c),
         .ext_end     (ext_c),
         .block_reload(blk_c),
         .addr_o      (addr_o[c*AW +: AW]),
         .cnt_o       (cnt_o[c*CW +: CW]),
         .tc_o        (tc_o[c]),
         .mask_o      (mask_o[c])
      );
   end
endmodule

// File: rtl/dmacu_chk.sv
module dmacu_chk #(
   parameter int NUM_CH = 4,
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int CHW    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 mask_wr,
   input logic                 step,
   input logic [CHW-1:0]       step_ch,
   input logic                 ext_eop,
   input logic [NUM_CH*AW-1:0] addr_o,
   input logic [NUM_CH*CW-1:0] cnt_o,
   input logic [NUM_CH-1:0]    tc_o,
   input logic [NUM_CH-1:0]    mask_o
);
   // R5: at most one channel steps per cycle, so at most one flag
   a_r5_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tc_o));

   // R11: nothing moves without a write, a step or an end pulse
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !step && !ext_eop) |=> ($stable(cnt_o) && $stable(addr_o)));

   // R10: masks change only by command or by end of process
   a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_wr && !step && !ext_eop) |=> $stable(mask_o));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R4: ordinary step lowers the count by one
      a_r4_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
         (step && step_ch == CHW'(c) && !wr_en && !ext_eop &&
          cnt_o[c*CW +: CW] != '0)
         |=> (cnt_o[c*CW +: CW] == $past(cnt_o[c*CW +: CW]) - CW'(1)));

      // R5: step at zero count raises that channel's flag next cycle
      a_r5_tc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         (step && step_ch == CHW'(c) && !wr_en && cnt_o[c*CW +: CW] == '0)
         |=> tc_o[c]);

      // R5: a flag is always caused by a step of the same channel
      a_r5_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
         tc_o[c] |-> ($past(step) && $past(step_ch) == CHW'(c)));
   end
endmodule

bind dma_cnt_unit dmacu_chk #(
   .NUM_CH(NUM_CH), .AW(AW), .CW(CW), .CHW(CHW)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .mask_wr(mask_wr),
   .step   (step),
   .step_ch(step_ch),
   .ext_eop(ext_eop),
   .addr_o (addr_o),
   .cnt_o  (cnt_o),
   .tc_o   (tc_o),
   .mask_o (mask_o)
);

// File: tb/dma_cnt_unit_bench.sv
`timescale 1ns/1ps
module dma_cnt_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 0, wr_sel = 0, clr_ptr = 0;
   logic [1:0]  wr_ch = 0, mode_ch = 0, mask_ch = 0, step_ch = 0;
   logic [7:0]  wr_data = 0;
   logic        mode_wr = 0, mode_auto = 0, mode_dec = 0;
   logic        mask_wr = 0, mask_val = 0, step = 0, ext_eop = 0, m2m = 0;
   logic [63:0] addr_o, cnt_o;
   logic [3:0]  tc_o, mask_o;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   dma_cnt_unit u_dma_cnt_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
      .wr_data(wr_data), .clr_ptr(clr_ptr), .mode_wr(mode_wr), .mode_ch(mode_ch),
      .mode_auto(mode_auto), .mode_dec(mode_dec), .mask_wr(mask_wr),
      .mask_ch(mask_ch), .mask_val(mask_val), .step(step), .step_ch(step_ch),
      .ext_eop(ext_eop), .m2m(m2m), .addr_o(addr_o), .cnt_o(cnt_o),
      .tc_o(tc_o), .mask_o(mask_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ad(input int c); return addr_o[c*16 +: 16]; endfunction
   function automatic logic [15:0] cn(input int c); return cnt_o[c*16 +: 16]; endfunction

   task automatic wr_b(input int c, input logic sel, input logic [7:0] v);
      @(negedge clk); wr_en = 1; wr_sel = sel; wr_ch = 2'(c); wr_data = v;
      @(negedge clk); wr_en = 0; wr_data = 8'h00;
   endtask
   task automatic wr16(input int c, input logic sel, input logic [15:0] v);
      wr_b(c, sel, v[7:0]);
      wr_b(c, sel, v[15:8]);
   endtask
   task automatic set_mode(input int c, input logic au, input logic dn);
      @(negedge clk); mode_wr = 1; mode_ch = 2'(c); mode_auto = au; mode_dec = dn;
      @(negedge clk); mode_wr = 0;
   endtask
   task automatic set_mask(input int c, input logic v);
      @(negedge clk); mask_wr = 1; mask_ch = 2'(c); mask_val = v;
      @(negedge clk); mask_wr = 0;
   endtask
   // one step; optional external end and same-cycle mask clear
   task automatic do_step(input int c, input logic ex, input logic mclr);
      @(negedge clk); step = 1; step_ch = 2'(c); ext_eop = ex;
      mask_wr = mclr; mask_ch = 2'(c); mask_val = 1'b0;
      @(negedge clk); step = 0; ext_eop = 0; mask_wr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", {28'd0, mask_o}, 32'hF);
      chk("R1 tc", {28'd0, tc_o}, 32'h0);
      chk("R1 cnt", cnt_o[31:0], 32'h0);
      chk("R1 addr", addr_o[63:32], 32'h0);

      // R3: stray low byte, then clear with non-zero data, then full load
      wr_b(0, 1'b0, 8'h55);
      @(negedge clk); clr_ptr = 1; wr_data = 8'hFF;
      @(negedge clk); clr_ptr = 0; wr_data = 8'h00;
      wr16(0, 1'b0, 16'h1234);
      chk("R3 ptr clear then R2 addr", {16'd0, ad(0)}, 32'h1234);

      // R2/R4/R5/R6/R7 sweep: every channel, counts 0..3, both modes
      for (int c = 0; c < 4; c++) begin
         for (int n = 0; n < 4; n++) begin
            logic au, dn;
            logic [15:0] a0;
            au = n[0];
            dn = c[0];
            a0 = 16'(16'h0100 * (c + 1) + 16'h00F0 + n);
            set_mode(c, au, dn);
            wr16(c, 1'b0, a0);
            wr16(c, 1'b1, 16'(n));
            chk("R2 cnt load", {16'd0, cn(c)}, n);
            chk("R2 addr load", {16'd0, ad(c)}, {16'd0, a0});
            set_mask(c, 1'b0);
            chk("R10 mask clear", {31'd0, mask_o[c]}, 0);
            for (int k = 1; k <= n; k++) begin
               do_step(c, 1'b0, 1'b0);
               chk("R4 cnt", {16'd0, cn(c)}, n - k);
               chk("R4 addr", {16'd0, ad(c)},
                   {16'd0, dn ? 16'(a0 - 16'(k)) : 16'(a0 + 16'(k))});
               chk("R5 no tc early", {28'd0, tc_o}, 0);
            end
            do_step(c, 1'b0, 1'b0);
            chk("R5 tc pulse", {28'd0, tc_o}, 32'(1 << c));
            if (au) begin
               chk("R6 cnt reload", {16'd0, cn(c)}, n);
               chk("R6 addr reload", {16'd0, ad(c)}, {16'd0, a0});
               chk("R6 mask kept", {31'd0, mask_o[c]}, 0);
            end else begin
               chk("R7 cnt wrap", {16'd0, cn(c)}, 32'hFFFF);
               chk("R7 addr stepped", {16'd0, ad(c)},
                   {16'd0, dn ? 16'(a0 - 16'(n + 1)) : 16'(a0 + 16'(n + 1))});
               chk("R7 mask set", {31'd0, mask_o[c]}, 1);
            end
            @(negedge clk);
            chk("R5 tc one cycle", {28'd0, tc_o}, 0);
            chk("R11 idle cnt", {16'd0, cn(c)}, au ? n : 32'hFFFF);
         end
      end

      // R10: end of process beats a same-cycle mask clear
      set_mode(3, 1'b0, 1'b0);
      wr16(3, 1'b1, 16'h0000);
      set_mask(3, 1'b0);
      do_step(3, 1'b0, 1'b1);
      chk("R10 eop beats clear", {31'd0, mask_o[3]}, 1);
      set_mask(3, 1'b0);
      set_mask(2, 1'b1);
      chk("R10 other channel untouched", {31'd0, mask_o[3]}, 0);

      // R8: external end without memory-to-memory, no reinit then reinit
      set_mode(2, 1'b0, 1'b0);
      wr16(2, 1'b0, 16'h4000);
      wr16(2, 1'b1, 16'h0005);
      set_mask(2, 1'b0);
      do_step(2, 1'b1, 1'b0);
      chk("R8 cnt stepped", {16'd0, cn(2)}, 4);
      chk("R8 addr stepped", {16'd0, ad(2)}, 32'h4001);
      chk("R8 mask set", {31'd0, mask_o[2]}, 1);
      chk("R8 no tc", {28'd0, tc_o}, 0);
      chk("R8 ch3 mask kept", {31'd0, mask_o[3]}, 0);
      set_mode(2, 1'b1, 1'b0);
      set_mask(2, 1'b0);
      do_step(2, 1'b0, 1'b0);
      do_step(2, 1'b1, 1'b0);
      chk("R8 reload cnt", {16'd0, cn(2)}, 5);
      chk("R8 reload addr", {16'd0, ad(2)}, 32'h4000);
      chk("R8 reload mask", {31'd0, mask_o[2]}, 0);

      // R9: memory-to-memory external end, channel 0 exception
      m2m = 1'b1;
      set_mode(0, 1'b1, 1'b0);
      set_mode(1, 1'b1, 1'b0);
      wr16(0, 1'b0, 16'h2000); wr16(0, 1'b1, 16'h0006);
      wr16(1, 1'b0, 16'h3000); wr16(1, 1'b1, 16'h0006);
      set_mask(0, 1'b0); set_mask(1, 1'b0);
      do_step(0, 1'b0, 1'b0); do_step(1, 1'b0, 1'b0);
      do_step(0, 1'b0, 1'b0); do_step(1, 1'b0, 1'b0);
      @(negedge clk); ext_eop = 1;
      @(negedge clk); ext_eop = 0;
      chk("R9 ch0 cnt not reloaded", {16'd0, cn(0)}, 4);
      chk("R9 ch0 addr not reloaded", {16'd0, ad(0)}, 32'h2002);
      chk("R9 ch0 mask set", {31'd0, mask_o[0]}, 1);
      chk("R9 ch1 cnt reloaded", {16'd0, cn(1)}, 6);
      chk("R9 ch1 addr reloaded", {16'd0, ad(1)}, 32'h3000);
      chk("R9 ch1 mask kept", {31'd0, mask_o[1]}, 0);
      chk("R9 ch2 untouched", {16'd0, cn(2)}, 5);
      m2m = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule